// File: doc/BRIEF.md
# Monochrome Glyph Expansion Writer

This block accelerates text drawing into an 8-bit-per-pixel frame buffer. The host sends glyph bitmaps as 32-bit words. Each word holds two rows of 16 one-bit pixels. The block expands every bit into a byte and writes it at a character-cell position that it tracks itself. Each byte goes through a plane-masked raster operation. The frame buffer is held inside the block, and a combinational read port gives the host access to it.

A glyph begins with a word on the start strobe and goes on with words on the continue strobe. The block keeps a row counter inside the current glyph. When the counter reaches the glyph height, the block steps the cell position to the right by the cell width and drops whatever remains of the word. It writes one pixel per clock. While it is expanding a word, `busy` is high and any new word is ignored.

Top module: `glyph_expand_writer`

## Requirements
- R1: After reset, `busy` is 0, `cur_pos` is 0 and every frame-buffer byte reads 0.
- R2: A data word is expanded as two rows, bits 31:16 first and then bits 15:0. Within a row, bit 15 is the leftmost pixel and bit 0 the rightmost.
- R3: A set bit writes `fg_color` when `bitmap_op` bit 1 is 1, and `bg_color` when it is 0.
- R4: A clear bit writes `bg_color`, unless `bitmap_op` bit 29 is 1. In that case the pixel is left unchanged.
- R5: Each row is placed at X = `cur_pos[31:16]` and Y = `cur_pos[15:0]` + row counter. Its first pixel is at byte address Y*FB_W + X, and the pixels that follow are at consecutive addresses.
- R6: A row is dropped, with no byte changed, in any of three cases: X ≥ FB_W, Y ≥ FB_H, or (Y*FB_W + X + 16) ≥ FB_W*FB_H. A dropped row still counts as a row.
- R7: The row counter increments after every row. When the counter equals `glyph_size[15:0]`, `glyph_size[31:16]` is added to `cur_pos[31:16]` and the rest of the word is discarded.
- R8: A start word clears the row counter before its first row. A continue word keeps the counter.
- R9: Each pixel write is dst' = op(dst, colour, `plane_mask`), where op is `bitmap_op[11:8]`:
  - 0 clears the masked bits.
  - 3 copies the masked bits of the colour.
  - 6 XORs in the masked colour.
  - 10 inverts the masked bits.
  - 15 sets the masked bits.
  - Any other code leaves the byte unchanged.
- R10: One pixel is processed per cycle. `busy` rises on the edge that accepts a word and stays high for 32 cycles, or for 16 cycles if the glyph completes on the first row. While `busy` is high, a start or continue strobe is ignored.
- R11: `pos_wr` loads `pos_wdata` into `cur_pos` while the block is idle. While `busy` is high, `pos_wr` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_wr | input | 1 | Accept `wr_data` as the first word of a glyph |
| cont_wr | input | 1 | Accept `wr_data` as a continuation word |
| wr_data | input | 32 | Two packed 16-pixel glyph rows |
| pos_wr | input | 1 | Load the cell position |
| pos_wdata | input | 32 | New position, X in 31:16 and Y in 15:0 |
| glyph_size | input | 32 | Cell width in 31:16, glyph height in 15:0 |
| fg_color | input | 8 | Foreground colour |
| bg_color | input | 8 | Background colour |
| bitmap_op | input | 32 | Bit 1 selects the colour for set bits, bit 29 makes clear bits transparent, bits 11:8 select the raster op |
| plane_mask | input | 8 | Bit planes that a write may alter |
| rd_addr | input | AW | Frame-buffer read address |
| rd_data | output | 8 | Frame-buffer byte at `rd_addr` (combinational) |
| busy | output | 1 | A word is being expanded |
| cur_pos | output | 32 | Current cell position |

## Verification
The bench raises a strobe at a falling edge. `busy` is first seen high at the next falling edge. The bench then counts every falling edge at which `busy` is still high, and that count must be exactly 16 or 32, as R10 says. Frame-buffer bytes and `cur_pos` are compared only at the first falling edge after `busy` drops. By then the last pixel write and the position step have both been registered on the same edge. Expected contents come from a reference model in the bench that applies the row rules word by word.

// File: rtl/glyph_pkg.sv
`timescale 1ns/1ps
package glyph_pkg;

    localparam logic [3:0] OP_ZERO = 4'd0;
    localparam logic [3:0] OP_COPY = 4'd3;
    localparam logic [3:0] OP_XOR  = 4'd6;
    localparam logic [3:0] OP_INV  = 4'd10;
    localparam logic [3:0] OP_ONES = 4'd15;

    localparam int SEL_FG_BIT = 1;
    localparam int TRANSP_BIT = 29;

    typedef struct packed {
        logic        busy;
        logic        half;
        logic [3:0]  pix;
        logic [15:0] rows;
        logic [31:0] data;
        logic [31:0] pos;
    } gx_state_t;

    function automatic logic [7:0] raster(input logic [3:0] op, input logic [7:0] dst,
                                          input logic [7:0] src, input logic [7:0] msk);
        logic [7:0] r;
        case (op)
            OP_ZERO: r = dst & ~msk;
            OP_COPY: r = (dst & ~msk) | (src & msk);
            OP_XOR:  r = dst ^ (src & msk);
            OP_INV:  r = dst ^ msk;
            OP_ONES: r = dst | msk;
            default: r = dst;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/glyph_rop.sv
`timescale 1ns/1ps
module glyph_rop
    import glyph_pkg::*;
(
    input  logic [3:0] op,
    input  logic [7:0] dst,
    input  logic [7:0] src,
    input  logic [7:0] msk,
    output logic [7:0] res
);
    always_comb res = raster(op, dst, src, msk);
endmodule

// File: rtl/glyph_row_gate.sv
`timescale 1ns/1ps
module glyph_row_gate #(
    parameter int FB_W = 32,
    parameter int FB_H = 16,
    localparam int FB_SIZE = FB_W * FB_H,
    localparam int AW = $clog2(FB_SIZE)
) (
    input  logic [31:0]   pos,
    input  logic [15:0]   rows,
    output logic          row_ok,
    output logic [AW-1:0] row_base
);
    localparam logic [33:0] W34 = 34'(FB_W);
    localparam logic [33:0] H34 = 34'(FB_H);
    localparam logic [33:0] S34 = 34'(FB_SIZE);

    logic [33:0] x, y, off;

    always_comb begin
        x        = {18'b0, pos[31:16]};
        y        = {18'b0, pos[15:0]} + {18'b0, rows};
        off      = y * W34 + x;
        row_ok   = (x < W34) && (y < H34) && ((off + 34'd16) < S34);
        row_base = off[AW-1:0];
    end
endmodule

// File: rtl/glyph_fb.sv
`timescale 1ns/1ps
module glyph_fb #(
    parameter int FB_W = 32,
    parameter int FB_H = 16,
    localparam int FB_SIZE = FB_W * FB_H,
    localparam int AW = $clog2(FB_SIZE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    logic [7:0] mem_q [FB_SIZE];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < FB_SIZE; i++) mem_q[i] <= 8'h00;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_a = mem_q[raddr_a];
        rdata_b = mem_q[raddr_b];
    end
endmodule

// File: rtl/glyph_expand_writer.sv
`timescale 1ns/1ps
module glyph_expand_writer
    import glyph_pkg::*;
#(
    parameter int FB_W = 32,
    parameter int FB_H = 16,
    localparam int FB_SIZE = FB_W * FB_H,
    localparam int AW = $clog2(FB_SIZE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_wr,
    input  logic          cont_wr,
    input  logic [31:0]   wr_data,
    input  logic          pos_wr,
    input  logic [31:0]   pos_wdata,
    input  logic [31:0]   glyph_size,
    input  logic [7:0]    fg_color,
    input  logic [7:0]    bg_color,
    input  logic [31:0]   bitmap_op,
    input  logic [7:0]    plane_mask,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy,
    output logic [31:0]   cur_pos
);
    gx_state_t st_q, st_d;

    logic [15:0]   row_bits;
    logic          cur_bit;
    logic          row_ok;
    logic [AW-1:0] row_base;
    logic [AW-1:0] pix_addr;
    logic [7:0]    src_col;
    logic [7:0]    dst_val;
    logic [7:0]    new_val;
    logic          fb_we;
    logic [15:0]   rows_inc;

    glyph_row_gate #(.FB_W(FB_W), .FB_H(FB_H)) u_gate (
        .pos      (st_q.pos),
        .rows     (st_q.rows),
        .row_ok   (row_ok),
        .row_base (row_base)
    );

    glyph_rop u_rop (
        .op  (bitmap_op[11:8]),
        .dst (dst_val),
        .src (src_col),
        .msk (plane_mask),
        .res (new_val)
    );

    glyph_fb #(.FB_W(FB_W), .FB_H(FB_H)) u_fb (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (fb_we),
        .waddr   (pix_addr),
        .wdata   (new_val),
        .raddr_a (pix_addr),
        .rdata_a (dst_val),
        .raddr_b (rd_addr),
        .rdata_b (rd_data)
    );

    // Pixel datapath: pick the row, the bit, the colour and the write strobe.
    always_comb begin
        row_bits = st_q.half ? st_q.data[15:0] : st_q.data[31:16];
        cur_bit  = row_bits[4'd15 - st_q.pix];
        pix_addr = row_base + AW'(st_q.pix);
        if (cur_bit)
            src_col = bitmap_op[SEL_FG_BIT] ? fg_color : bg_color;
        else
            src_col = bg_color;
        fb_we    = st_q.busy && row_ok && (cur_bit || !bitmap_op[TRANSP_BIT]);
        rows_inc = st_q.rows + 16'd1;
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (pos_wr) st_d.pos = pos_wdata;
            if (start_wr || cont_wr) begin
                st_d.busy = 1'b1;
                st_d.half = 1'b0;
                st_d.pix  = 4'd0;
                st_d.data = wr_data;
                if (start_wr) st_d.rows = 16'd0;
            end
        end else if (st_q.pix != 4'd15) begin
            st_d.pix = st_q.pix + 4'd1;
        end else begin
            st_d.pix  = 4'd0;
            st_d.rows = rows_inc;
            if (rows_inc == glyph_size[15:0]) begin
                st_d.pos  = st_q.pos + {glyph_size[31:16], 16'h0000};
                st_d.busy = 1'b0;
            end else if (!st_q.half) begin
                st_d.half = 1'b1;
            end else begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign cur_pos = st_q.pos;

endmodule

// File: rtl/glyph_expand_writer_chk.sv
`timescale 1ns/1ps
module glyph_expand_writer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_wr,
    input logic        cont_wr,
    input logic        pos_wr,
    input logic        busy,
    input logic [31:0] cur_pos,
    input logic        fb_we,
    input logic        cur_bit,
    input logic [31:0] bitmap_op
);
    logic [5:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n)                   run_len <= '0;
        else if (!busy)               run_len <= '0;
        else if (run_len != 6'd63)    run_len <= run_len + 6'd1;
    end

    AST_ACCEPT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (start_wr || cont_wr)) |=> busy);                        // R10
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fb_we);                                                 // R10
    AST_WORD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 6'd16 || run_len == 6'd32));           // R10
    AST_TRANSPARENT_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_we && bitmap_op[29]) |-> cur_bit);                             // R4
    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_pos) |-> (($past(pos_wr) && !$past(busy)) || $fell(busy))); // R7
endmodule

bind glyph_expand_writer glyph_expand_writer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_wr  (start_wr),
    .cont_wr   (cont_wr),
    .pos_wr    (pos_wr),
    .busy      (busy),
    .cur_pos   (cur_pos),
    .fb_we     (fb_we),
    .cur_bit   (cur_bit),
    .bitmap_op (bitmap_op)
);

// File: tb/sim_glyph_expand_writer.sv
`timescale 1ns/1ps
module sim_glyph_expand_writer;
    localparam int W  = 32;
    localparam int H  = 16;
    localparam int SZ = W * H;
    localparam int AW = $clog2(SZ);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_wr = 1'b0, cont_wr = 1'b0, pos_wr = 1'b0;
    logic [31:0]   wr_data = '0, pos_wdata = '0, glyph_size = '0, bitmap_op = '0;
    logic [7:0]    fg_color = 8'hA5, bg_color = 8'h3C, plane_mask = 8'hFF;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy;
    logic [31:0]   cur_pos;

    int checks = 0;
    int fails  = 0;

    logic [7:0]  m_mem [SZ];
    logic [31:0] m_pos;
    logic [15:0] m_rows;

    always #5 clk = ~clk;

    glyph_expand_writer #(.FB_W(W), .FB_H(H)) u0 (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .cont_wr(cont_wr),
        .wr_data(wr_data), .pos_wr(pos_wr), .pos_wdata(pos_wdata),
        .glyph_size(glyph_size), .fg_color(fg_color), .bg_color(bg_color),
        .bitmap_op(bitmap_op), .plane_mask(plane_mask), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .cur_pos(cur_pos)
    );

    typedef struct packed {
        logic        is_start;
        logic [31:0] data;
        logic [31:0] size;
        logic [31:0] bop;
        logic [7:0]  pmask;
        logic [5:0]  cyc;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 32'h8001_FFFF, 32'h000A_0004, 32'h0000_0302, 8'hFF, 6'd32}, // R2 R3 copy fg
        '{1'b0, 32'h0F0F_F0F0, 32'h000A_0004, 32'h2000_0302, 8'hFF, 6'd32}, // R4 R8 R7 end on 2nd row
        '{1'b1, 32'hAAAA_5555, 32'h0008_0001, 32'h0000_0300, 8'hFF, 6'd16}, // R3 bg, R7 early end
        '{1'b1, 32'hFFFF_0000, 32'h0004_0003, 32'h0000_0602, 8'h0F, 6'd32}, // R9 xor
        '{1'b0, 32'h1234_5678, 32'h0004_0003, 32'h0000_0002, 8'hF0, 6'd16}, // R9 clear, R8
        '{1'b1, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0A02, 8'hFF, 6'd32}, // R9 invert
        '{1'b1, 32'hC3C3_3C3C, 32'h0000_0002, 32'h0000_0F02, 8'h81, 6'd32}, // R9 set
        '{1'b1, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0502, 8'hFF, 6'd32}  // R9 other code
    };

    function automatic logic [7:0] m_rop(input logic [3:0] op, input logic [7:0] d,
                                         input logic [7:0] s, input logic [7:0] m);
        case (op)
            4'd0:    return d & ~m;
            4'd3:    return (d & ~m) | (s & m);
            4'd6:    return d ^ (s & m);
            4'd10:   return d ^ m;
            4'd15:   return d | m;
            default: return d;
        endcase
    endfunction

    task automatic model_word(input logic st, input logic [31:0] d);
        logic [15:0] rb;
        int x, y, off;
        if (st) m_rows = 16'd0;
        for (int h = 0; h < 2; h++) begin
            rb  = (h == 0) ? d[31:16] : d[15:0];
            x   = int'(m_pos[31:16]);
            y   = int'(m_pos[15:0]) + int'(m_rows);
            off = y * W + x;
            if (x < W && y < H && off + 16 < SZ) begin
                for (int i = 0; i < 16; i++) begin
                    if (rb[15 - i])
                        m_mem[off + i] = m_rop(bitmap_op[11:8], m_mem[off + i],
                                               bitmap_op[1] ? fg_color : bg_color, plane_mask);
                    else if (!bitmap_op[29])
                        m_mem[off + i] = m_rop(bitmap_op[11:8], m_mem[off + i], bg_color, plane_mask);
                end
            end
            m_rows = m_rows + 16'd1;
            if (m_rows == glyph_size[15:0]) begin
                m_pos = m_pos + {glyph_size[31:16], 16'h0000};
                break;
            end
        end
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_fb(input string req);
        int bad = -1;
        logic [7:0] act = '0;
        for (int a = 0; a < SZ; a++) begin
            rd_addr = AW'(a);
            #1;
            if (rd_data !== m_mem[a] && bad < 0) begin
                bad = a;
                act = rd_data;
            end
        end
        check(bad < 0, req, {24'h0, act}, (bad < 0) ? 32'h0 : {24'h0, m_mem[bad]});
    endtask

    task automatic load_pos(input logic [31:0] p);
        @(negedge clk);
        pos_wr = 1'b1; pos_wdata = p;
        @(negedge clk);
        pos_wr = 1'b0;
        m_pos = p;
    endtask

    task automatic send(input logic st, input logic [31:0] d, output int cyc);
        @(negedge clk);
        start_wr = st; cont_wr = !st; wr_data = d;
        @(negedge clk);
        start_wr = 1'b0; cont_wr = 1'b0;
        cyc = 0;
        while (busy && cyc < 100) begin
            cyc++;
            @(negedge clk);
        end
        model_word(st, d);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cyc;
        for (int a = 0; a < SZ; a++) m_mem[a] = 8'h00;
        m_pos = '0; m_rows = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy", {31'h0, busy}, 32'h0);
        check(cur_pos == 32'h0, "R1 pos", cur_pos, 32'h0);
        check_fb("R1 fb");

        // Table walk: R2 R3 R4 R5 R7 R8 R9 R10
        load_pos(32'h0002_0001);
        for (int v = 0; v < NV; v++) begin
            glyph_size = TBL[v].size;
            bitmap_op  = TBL[v].bop;
            plane_mask = TBL[v].pmask;
            send(TBL[v].is_start, TBL[v].data, cyc);
            check(cyc == int'(TBL[v].cyc), "R10 cycles", 32'(cyc), {26'h0, TBL[v].cyc});
            check(cur_pos == m_pos, "R7 pos", cur_pos, m_pos);
            check_fb("R2 R5 R9 fb");
        end

        // R6: row drops
        glyph_size = 32'h0000_0010; bitmap_op = 32'h0000_0302; plane_mask = 8'hFF;
        load_pos(32'h0020_0000);                 // X == width
        send(1'b1, 32'hFFFF_FFFF, cyc);
        check_fb("R6 x out");
        load_pos(32'h0000_0010);                 // Y == height
        send(1'b1, 32'hFFFF_FFFF, cyc);
        check_fb("R6 y out");
        load_pos(32'h0010_000F);                 // offset+16 == size
        send(1'b1, 32'hFFFF_0000, cyc);
        check_fb("R6 size edge");
        load_pos(32'h000F_000F);                 // offset+16 == size-1, written
        send(1'b1, 32'h8001_0000, cyc);
        check(rd_data === m_mem[SZ-1], "R6 last row", {24'h0, rd_data}, {24'h0, m_mem[SZ-1]});
        check_fb("R6 last row fb");

        // R6 R8: counter carries rows past the bottom on a continue word
        glyph_size = 32'h0000_0004;
        load_pos(32'h0000_000E);
        send(1'b1, 32'h0FF0_F00F, cyc);
        send(1'b0, 32'hFFFF_FFFF, cyc);
        check(cyc == 32, "R6 dropped rows keep slots", 32'(cyc), 32'd32);
        check_fb("R6 R8 bottom");

        // R10 R11: strobes and position load ignored while busy
        glyph_size = 32'h0003_0002; bitmap_op = 32'h0000_0602;
        load_pos(32'h0004_0003);
        @(negedge clk);
        start_wr = 1'b1; wr_data = 32'h00FF_FF00;
        @(negedge clk);
        start_wr = 1'b0;
        repeat (4) @(negedge clk);
        cont_wr = 1'b1; pos_wr = 1'b1; wr_data = 32'hFFFF_FFFF; pos_wdata = 32'h0000_0000;
        @(negedge clk);
        cont_wr = 1'b0; pos_wr = 1'b0;
        cyc = 5;
        while (busy && cyc < 100) begin
            cyc++;
            @(negedge clk);
        end
        model_word(1'b1, 32'h00FF_FF00);
        check(cyc == 32, "R10 busy ignore len", 32'(cyc), 32'd32);
        check(cur_pos == m_pos, "R11 pos ignored busy", cur_pos, m_pos);
        check_fb("R10 ignore fb");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule